// File: doc/BRIEF.md
# Serial Port with Flow-Controlled FIFOs

This block is an asynchronous serial transceiver for a register-mapped peripheral slot. Software pushes bytes into a transmit queue through a data register. The serial engine sends them one frame at a time. Incoming frames are collected into a receive queue, and software drains that queue by reading the same data register. A frame is a low start bit, eight data bits sent least significant bit first, an optional parity bit, and a single high stop bit. The line rests high between frames.

A 12-bit reload value sets the rate. A divider produces one tick every reload+1 clocks, and one bit lasts eight ticks. The receiver confirms a start bit at its midpoint, and after that it samples each bit at its centre. Two active-low handshake lines throttle traffic. The peer's clear-to-send input must be low before a new frame may leave. The ready-to-receive output goes high while the receive queue has no room. Sticky flags record parity mismatches, bad stop bits and bytes lost to a full queue. Writing ones to the status register clears them.

Register map (addr_i): 0 = data (a write queues a byte for sending; a read returns the oldest received byte and pops it); 1 = status; 2 = control; 3 = divider reload.

Top module: `sio_link`

## Requirements
- R1: One cycle of the internal reset sync after reset is released: txd_o is 1, rtsn_o is 0, status reads 0x001 (only bit 0, transmit queue empty, set), control reads 0, and the reload register reads the RELOAD_INIT parameter (default 15).
- R2: The divider ticks every reload+1 clocks, and each transmitted bit, the start bit included, lasts exactly 8*(reload+1) clocks.
- R3: A transmitted frame is: a start bit at 0; the eight data bits, bit 0 first; a parity bit only when control bit 2 is 1; one stop bit at 1. txd_o is 1 when no frame is being sent.
- R4: The parity bit is the XOR of the eight data bits when control bit 3 is 0 (even) and the inverse of that XOR when control bit 3 is 1 (odd). The same rule checks received frames.
- R5: A frame begins only when all three hold: control bit 0 (transmit enable) is 1, the transmit queue is not empty, and ctsn_i is 0. Once it has begun, it completes even if ctsn_i goes high.
- R6: The receiver accepts a start bit only if the line is still low half a bit after the falling edge. A low pulse shorter than that stores nothing.
- R7: Received bytes are queued in arrival order. A read of address 0 returns the oldest byte and pops it. Status bit 2 is 1 while the queue holds data, and status bit 3 is 1 while it is full.
- R8: rtsn_o is 1 exactly while the receive queue is full, and 0 otherwise.
- R9: A received parity bit that does not match R4 sets sticky status bit 4. The byte is still queued.
- R10: A received stop bit sampled as 0 sets sticky status bit 5.
- R11: A byte that completes while the receive queue is full is discarded. The queued bytes are left unchanged, and sticky status bit 6 is set.
- R12: Writing status with bit 4, 5 or 6 set clears only the corresponding flags.
- R13: While control bit 1 (receive enable) is 0, frames on rxd_i are ignored and nothing is queued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 2 | Register select |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (pops the receive queue at address 0) |
| wdata_i | input | 12 | Write data |
| rdata_o | output | 12 | Read data for the selected register |
| txd_o | output | 1 | Serial transmit line |
| rxd_i | input | 1 | Serial receive line |
| rtsn_o | output | 1 | Ready to receive, active low |
| ctsn_i | input | 1 | Clear to send from the peer, active low |

## Verification
The bench targets the handshake edges. A queued byte is held back while clear-to-send is high or transmit is disabled, and a frame whose clear-to-send is withdrawn midway must still finish. A design that checked the handshake on every bit would truncate that frame. A design that ignored it would send too early. On the receive side, the bench fills the queue to its depth and sends one more byte. It then expects rtsn_o high, the overrun flag set and the original bytes intact, so a design that overwrote the oldest entry or advanced the write pointer is caught. It also sends a short low glitch, frames with wrong parity and frames with a low stop bit. These catch a receiver that skips start qualification, samples at bit edges, or drops flagged bytes.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int DIV_W     = 12;
  localparam int REG_W     = 12;
  localparam int CHAR_W    = 8;
  localparam int SUB_TICKS = 8;
  localparam int SUB_W     = $clog2(SUB_TICKS);
  localparam int IDX_W     = $clog2(CHAR_W);
  localparam int CTRL_W    = 4;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;
  localparam logic [1:0] A_SCAL = 2'd3;

  localparam int SB_TXE  = 0;
  localparam int SB_TXF  = 1;
  localparam int SB_RXA  = 2;
  localparam int SB_RXF  = 3;
  localparam int SB_PERR = 4;
  localparam int SB_FERR = 5;
  localparam int SB_OVR  = 6;

  localparam int CB_TXEN = 0;
  localparam int CB_RXEN = 1;
  localparam int CB_PEN  = 2;
  localparam int CB_PODD = 3;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} sio_state_e;
endpackage

// File: rtl/sio_fifo.sv
module sio_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0]    cnt_q, cnt_d;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push_i) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (pop_i)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    if (push_i && !pop_i) cnt_d = cnt_q + 1'b1;
    else if (pop_i && !push_i) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rp_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));

  // R7: storage order is only kept if callers never push into a full queue
  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R7: pops only from a queue that holds data
  assert_no_underflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/sio_tx.sv
module sio_tx import sio_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              cts_n_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              empty_i,
  input  logic [CHAR_W-1:0] data_i,
  output logic              pop_o,
  output logic              txd_o
);
  sio_state_e        st_q, st_d;
  logic [SUB_W-1:0]  sub_q, sub_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [CHAR_W-1:0] sh_q, sh_d;
  logic              par_q, par_d, pe_q, pe_d, txd_q, txd_d;

  always_comb begin
    st_d  = st_q;
    sub_d = sub_q;
    idx_d = idx_q;
    sh_d  = sh_q;
    par_d = par_q;
    pe_d  = pe_q;
    txd_d = txd_q;
    pop_o = 1'b0;
    if (tick_i) begin
      if (st_q == S_IDLE) begin
        txd_d = 1'b1;
        if (en_i && !cts_n_i && !empty_i) begin
          pop_o = 1'b1;
          sh_d  = data_i;
          par_d = par_odd_i ^ (^data_i);
          pe_d  = par_en_i;
          sub_d = '0;
          st_d  = S_START;
          txd_d = 1'b0;
        end
      end else begin
        sub_d = sub_q + 1'b1;
        if (sub_q == SUB_W'(SUB_TICKS - 1)) begin
          unique case (st_q)
            S_START: begin
              st_d  = S_DATA;
              idx_d = '0;
              txd_d = sh_q[0];
            end
            S_DATA: begin
              if (idx_q == IDX_W'(CHAR_W - 1)) begin
                st_d  = pe_q ? S_PAR : S_STOP;
                txd_d = pe_q ? par_q : 1'b1;
              end else begin
                idx_d = idx_q + 1'b1;
                sh_d  = sh_q >> 1;
                txd_d = sh_q[1];
              end
            end
            S_PAR: begin
              st_d  = S_STOP;
              txd_d = 1'b1;
            end
            default: begin
              st_d  = S_IDLE;
              txd_d = 1'b1;
            end
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      sub_q <= '0;
      idx_q <= '0;
      sh_q  <= '0;
      par_q <= 1'b0;
      pe_q  <= 1'b0;
      txd_q <= 1'b1;
    end else begin
      st_q  <= st_d;
      sub_q <= sub_d;
      idx_q <= idx_d;
      sh_q  <= sh_d;
      par_q <= par_d;
      pe_q  <= pe_d;
      txd_q <= txd_d;
    end
  end

  assign txd_o = txd_q;

  // R5: a frame leaves idle only while the peer reported clear-to-send
  assert_start_needs_cts_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_START && $past(st_q) == S_IDLE) |-> !$past(cts_n_i));
  // R2: the line can only change on a divider tick
  assert_line_on_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tick_i) |-> $stable(txd_o));
endmodule

// File: rtl/sio_rx.sv
module sio_rx import sio_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              rxd_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  output logic              done_o,
  output logic [CHAR_W-1:0] data_o,
  output logic              perr_o,
  output logic              ferr_o
);
  localparam int HALF = SUB_TICKS / 2;

  sio_state_e        st_q, st_d;
  logic [SUB_W-1:0]  sub_q, sub_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [CHAR_W-1:0] sh_q, sh_d;
  logic              pb_q, pb_d, pe_q, pe_d, odd_q, odd_d;

  always_comb begin
    st_d   = st_q;
    sub_d  = sub_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    pb_d   = pb_q;
    pe_d   = pe_q;
    odd_d  = odd_q;
    done_o = 1'b0;
    perr_o = 1'b0;
    ferr_o = 1'b0;
    if (tick_i) begin
      if (st_q == S_IDLE) begin
        if (en_i && !rxd_i) begin
          st_d  = S_START;
          sub_d = '0;
          pe_d  = par_en_i;
          odd_d = par_odd_i;
        end
      end else if (st_q == S_START) begin
        sub_d = sub_q + 1'b1;
        if (sub_q == SUB_W'(HALF - 1)) begin
          st_d  = rxd_i ? S_IDLE : S_DATA;
          sub_d = '0;
          idx_d = '0;
        end
      end else begin
        sub_d = sub_q + 1'b1;
        if (sub_q == SUB_W'(SUB_TICKS - 1)) begin
          unique case (st_q)
            S_DATA: begin
              sh_d  = {rxd_i, sh_q[CHAR_W-1:1]};
              idx_d = idx_q + 1'b1;
              if (idx_q == IDX_W'(CHAR_W - 1)) st_d = pe_q ? S_PAR : S_STOP;
            end
            S_PAR: begin
              pb_d = rxd_i;
              st_d = S_STOP;
            end
            default: begin
              done_o = 1'b1;
              ferr_o = !rxd_i;
              perr_o = pe_q && (pb_q != (odd_q ^ (^sh_q)));
              st_d   = S_IDLE;
            end
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      sub_q <= '0;
      idx_q <= '0;
      sh_q  <= '0;
      pb_q  <= 1'b0;
      pe_q  <= 1'b0;
      odd_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      sub_q <= sub_d;
      idx_q <= idx_d;
      sh_q  <= sh_d;
      pb_q  <= pb_d;
      pe_q  <= pe_d;
      odd_q <= odd_d;
    end
  end

  assign data_o = sh_q;

  // R6: a qualified start must have seen a low line at the half-bit check
  assert_start_qualified_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_DATA && $past(st_q) == S_START) |-> !$past(rxd_i));
endmodule

// File: rtl/sio_link.sv
module sio_link import sio_pkg::*; #(
  parameter int               FIFO_DEPTH  = 4,
  parameter logic [DIV_W-1:0] RELOAD_INIT = 12'd15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       addr_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             txd_o,
  input  logic             rxd_i,
  output logic             rtsn_o,
  input  logic             ctsn_i
);
  logic [1:0]        rst_sync_q, rxd_sync_q, cts_sync_q;
  logic              rst_n;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [DIV_W-1:0]  scal_q, scal_d, div_q, div_d;
  logic              perr_q, perr_d, ferr_q, ferr_d, ovr_q, ovr_d;
  logic              tick, wr_data, wr_stat, wr_ctrl, wr_scal, rd_data;
  logic              tx_push, tx_pop, tx_empty, tx_full;
  logic              rx_push, rx_pop, rx_empty, rx_full;
  logic              rx_done, rx_perr, rx_ferr;
  logic [CHAR_W-1:0] tx_head, rx_head, rx_byte;

  // reset: asserted at once, released two clocks later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      rxd_sync_q <= 2'b11;
      cts_sync_q <= 2'b11;
    end else begin
      rxd_sync_q <= {rxd_sync_q[0], rxd_i};
      cts_sync_q <= {cts_sync_q[0], ctsn_i};
    end
  end

  assign wr_data = wr_i && (addr_i == A_DATA);
  assign wr_stat = wr_i && (addr_i == A_STAT);
  assign wr_ctrl = wr_i && (addr_i == A_CTRL);
  assign wr_scal = wr_i && (addr_i == A_SCAL);
  assign rd_data = rd_i && (addr_i == A_DATA);
  assign tx_push = wr_data && !tx_full;
  assign rx_pop  = rd_data && !rx_empty;
  assign rx_push = rx_done && !rx_full;
  assign tick    = (div_q == '0);

  always_comb begin
    ctrl_d = wr_ctrl ? wdata_i[CTRL_W-1:0] : ctrl_q;
    scal_d = wr_scal ? wdata_i[DIV_W-1:0] : scal_q;
    div_d  = tick ? scal_q : div_q - 1'b1;
    perr_d = perr_q;
    ferr_d = ferr_q;
    ovr_d  = ovr_q;
    if (wr_stat && wdata_i[SB_PERR]) perr_d = 1'b0;
    if (wr_stat && wdata_i[SB_FERR]) ferr_d = 1'b0;
    if (wr_stat && wdata_i[SB_OVR])  ovr_d  = 1'b0;
    if (rx_done && rx_perr)          perr_d = 1'b1;
    if (rx_done && rx_ferr)          ferr_d = 1'b1;
    if (rx_done && rx_full)          ovr_d  = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      scal_q <= RELOAD_INIT;
      div_q  <= RELOAD_INIT;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      scal_q <= scal_d;
      div_q  <= div_d;
      perr_q <= perr_d;
      ferr_q <= ferr_d;
      ovr_q  <= ovr_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_DATA: rdata_o[CHAR_W-1:0] = rx_head;
      A_STAT: begin
        rdata_o[SB_TXE]  = tx_empty;
        rdata_o[SB_TXF]  = tx_full;
        rdata_o[SB_RXA]  = !rx_empty;
        rdata_o[SB_RXF]  = rx_full;
        rdata_o[SB_PERR] = perr_q;
        rdata_o[SB_FERR] = ferr_q;
        rdata_o[SB_OVR]  = ovr_q;
      end
      A_CTRL: rdata_o[CTRL_W-1:0] = ctrl_q;
      A_SCAL: rdata_o = scal_q;
    endcase
  end

  sio_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(CHAR_W)) u_txq (
    .clk_i(clk_i), .rst_ni(rst_n), .push_i(tx_push), .pop_i(tx_pop),
    .wdata_i(wdata_i[CHAR_W-1:0]), .rdata_o(tx_head), .empty_o(tx_empty), .full_o(tx_full));

  sio_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(CHAR_W)) u_rxq (
    .clk_i(clk_i), .rst_ni(rst_n), .push_i(rx_push), .pop_i(rx_pop),
    .wdata_i(rx_byte), .rdata_o(rx_head), .empty_o(rx_empty), .full_o(rx_full));

  sio_tx u_tx (
    .clk_i(clk_i), .rst_ni(rst_n), .tick_i(tick), .en_i(ctrl_q[CB_TXEN]),
    .cts_n_i(cts_sync_q[1]), .par_en_i(ctrl_q[CB_PEN]), .par_odd_i(ctrl_q[CB_PODD]),
    .empty_i(tx_empty), .data_i(tx_head), .pop_o(tx_pop), .txd_o(txd_o));

  sio_rx u_rx (
    .clk_i(clk_i), .rst_ni(rst_n), .tick_i(tick), .en_i(ctrl_q[CB_RXEN]),
    .rxd_i(rxd_sync_q[1]), .par_en_i(ctrl_q[CB_PEN]), .par_odd_i(ctrl_q[CB_PODD]),
    .done_o(rx_done), .data_o(rx_byte), .perr_o(rx_perr), .ferr_o(rx_ferr));

  assign rtsn_o = rx_full;

  // R8: ready-to-receive only withdraws right after a byte was stored
  assert_rtsn_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(rtsn_o) |-> $past(rx_push));
  // R9 and R12: the parity flag only drops on a clearing write
  assert_perr_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(perr_q) |-> $past(wr_stat && wdata_i[SB_PERR]));
  // R10 and R12: the framing flag only drops on a clearing write
  assert_ferr_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(ferr_q) |-> $past(wr_stat && wdata_i[SB_FERR]));
  // R11: a byte finishing into a full queue raises the overrun flag
  assert_overrun_R11: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rx_done && rx_full) |=> ovr_q);
endmodule

// File: tb/sio_link_bench.sv
module sio_link_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {parity enable, parity odd, byte}
  localparam logic [9:0] VEC [NVEC] = '{
    {2'b00, 8'h00}, {2'b10, 8'hA5}, {2'b11, 8'hA5}, {2'b10, 8'h01},
    {2'b11, 8'h00}, {2'b00, 8'hFF}, {2'b11, 8'h7E}, {2'b10, 8'h80}};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [11:0] wdata = '0;
  logic [11:0] rdata;
  logic        txd, rtsn;
  logic        rxd = 1'b1, ctsn = 1'b0;
  int          checks = 0, fails = 0, bitc = 32;
  bit          done = 1'b0;

  sio_link u_sio_link (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .txd_o(txd), .rxd_i(rxd),
    .rtsn_o(rtsn), .ctsn_i(ctsn));

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [11:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, input bit pop, output logic [11:0] v);
    @(negedge clk);
    addr = a; rd = pop;
    #1 v = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic capture_tx(input bit pe, input bit drop_cts, output logic [7:0] d,
                            output logic pb, output logic sb);
    int t = 0;
    while (txd === 1'b1 && t < 20000) begin @(negedge clk); t++; end
    if (drop_cts) ctsn = 1'b1;
    repeat (bitc / 2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      repeat (bitc) @(negedge clk);
      d[i] = txd;
    end
    pb = 1'b0;
    if (pe) begin repeat (bitc) @(negedge clk); pb = txd; end
    repeat (bitc) @(negedge clk);
    sb = txd;
    repeat (bitc / 2 + 2) @(negedge clk);
  endtask

  task automatic send_rx(input logic [7:0] d, input bit pe, input bit pbit, input bit sbit);
    @(negedge clk);
    rxd = 1'b0;
    repeat (bitc) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (bitc) @(negedge clk);
    end
    if (pe) begin rxd = pbit; repeat (bitc) @(negedge clk); end
    rxd = sbit;
    repeat (bitc) @(negedge clk);
    rxd = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic drain();
    logic [11:0] v;
    for (int i = 0; i < 8; i++) begin
      reg_rd(2'd1, 1'b0, v);
      if (v[2]) reg_rd(2'd0, 1'b1, v);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [11:0] v;
    logic [7:0]  d;
    logic        pb, sb;
    int          lowlen, lows;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 txd idle", int'(txd), 1);
    check("R1 rtsn", int'(rtsn), 0);
    reg_rd(2'd1, 1'b0, v); check("R1 status", int'(v), 'h001);
    reg_rd(2'd2, 1'b0, v); check("R1 control", int'(v), 0);
    reg_rd(2'd3, 1'b0, v); check("R1 reload", int'(v), 15);

    reg_wr(2'd3, 12'd3);
    bitc = 32;

    // vector table: transmit then receive each entry
    for (int i = 0; i < NVEC; i++) begin
      logic       pe, po;
      logic [7:0] b;
      pe = VEC[i][9]; po = VEC[i][8]; b = VEC[i][7:0];
      reg_wr(2'd2, {8'd0, po, pe, 2'b11});
      reg_wr(2'd0, {4'd0, b});
      capture_tx(pe, 1'b0, d, pb, sb);
      check("R3 tx data", int'(d), int'(b));
      check("R3 tx stop", int'(sb), 1);
      if (pe) check("R4 tx parity", int'(pb), int'(po ^ (^b)));
      send_rx(b, pe, po ^ (^b), 1'b1);
      reg_rd(2'd1, 1'b0, v);
      check("R7 rx avail", int'(v[2]), 1);
      check("R9 no parity error", int'(v[4]), 0);
      reg_rd(2'd0, 1'b1, v);
      check("R7 rx data", int'(v[7:0]), int'(b));
    end

    // R2: start bit length at reload 5
    reg_wr(2'd3, 12'd5);
    bitc = 48;
    reg_wr(2'd2, 12'h001);
    reg_wr(2'd0, 12'h001);
    lows = 0;
    while (txd === 1'b1 && lows < 2000) begin @(negedge clk); lows++; end
    lowlen = 0;
    while (txd === 1'b0 && lowlen < 2000) begin lowlen++; @(negedge clk); end
    check("R2 bit length", lowlen, 48);
    repeat (12 * 48) @(negedge clk);
    check("R3 idle after frame", int'(txd), 1);
    reg_wr(2'd3, 12'd3);
    bitc = 32;

    // R5: gating by enable and clear-to-send
    reg_wr(2'd2, 12'h000);
    reg_wr(2'd0, 12'h05A);
    lows = 0;
    repeat (400) begin @(negedge clk); if (txd === 1'b0) lows++; end
    check("R5 held while disabled", lows, 0);
    ctsn = 1'b1;
    reg_wr(2'd2, 12'h001);
    lows = 0;
    repeat (400) begin @(negedge clk); if (txd === 1'b0) lows++; end
    check("R5 held while ctsn high", lows, 0);
    reg_rd(2'd1, 1'b0, v); check("R5 byte still queued", int'(v[0]), 0);
    ctsn = 1'b0;
    capture_tx(1'b0, 1'b1, d, pb, sb);
    check("R5 frame completes after ctsn rise", int'(d), 'h5A);
    check("R5 stop after ctsn rise", int'(sb), 1);
    ctsn = 1'b0;

    // R8/R11: fill receive queue then overrun
    reg_wr(2'd2, 12'h002);
    send_rx(8'h11, 1'b0, 1'b0, 1'b1);
    send_rx(8'h22, 1'b0, 1'b0, 1'b1);
    send_rx(8'h33, 1'b0, 1'b0, 1'b1);
    check("R8 rtsn low before full", int'(rtsn), 0);
    send_rx(8'h44, 1'b0, 1'b0, 1'b1);
    check("R8 rtsn high when full", int'(rtsn), 1);
    reg_rd(2'd1, 1'b0, v); check("R7 full flag", int'(v[3]), 1);
    send_rx(8'h55, 1'b0, 1'b0, 1'b1);
    reg_rd(2'd1, 1'b0, v); check("R11 overrun flag", int'(v[6]), 1);
    reg_rd(2'd0, 1'b1, v); check("R11 oldest kept", int'(v[7:0]), 'h11);
    @(negedge clk);
    check("R8 rtsn low after pop", int'(rtsn), 0);
    reg_rd(2'd0, 1'b1, v); check("R7 order 2", int'(v[7:0]), 'h22);
    reg_rd(2'd0, 1'b1, v); check("R7 order 3", int'(v[7:0]), 'h33);
    reg_rd(2'd0, 1'b1, v); check("R11 last kept", int'(v[7:0]), 'h44);
    reg_rd(2'd1, 1'b0, v); check("R11 dropped byte absent", int'(v[2]), 0);
    reg_wr(2'd1, 12'h040);
    reg_rd(2'd1, 1'b0, v); check("R12 overrun cleared", int'(v[6]), 0);

    // R9: parity mismatch
    reg_wr(2'd2, 12'h006);
    send_rx(8'h3C, 1'b1, 1'b1, 1'b1);
    reg_rd(2'd1, 1'b0, v); check("R9 parity flag", int'(v[4]), 1);
    reg_rd(2'd0, 1'b1, v); check("R9 byte stored", int'(v[7:0]), 'h3C);
    send_rx(8'h3C, 1'b1, 1'b0, 1'b1);
    reg_rd(2'd1, 1'b0, v); check("R9 flag sticky", int'(v[4]), 1);
    reg_rd(2'd0, 1'b1, v);

    // R10: low stop bit
    send_rx(8'h81, 1'b1, 1'b0, 1'b0);
    repeat (12 * 32) @(negedge clk);
    reg_rd(2'd1, 1'b0, v); check("R10 framing flag", int'(v[5]), 1);
    drain();
    reg_wr(2'd1, 12'h010);
    reg_rd(2'd1, 1'b0, v);
    check("R12 parity cleared", int'(v[4]), 0);
    check("R12 framing kept", int'(v[5]), 1);
    reg_wr(2'd1, 12'h020);
    reg_rd(2'd1, 1'b0, v); check("R12 framing cleared", int'(v[5]), 0);

    // R6: short low glitch
    reg_wr(2'd2, 12'h002);
    @(negedge clk); rxd = 1'b0;
    repeat (6) @(negedge clk); rxd = 1'b1;
    repeat (12 * 32) @(negedge clk);
    reg_rd(2'd1, 1'b0, v); check("R6 glitch ignored", int'(v[2]), 0);

    // R13: receiver disabled
    reg_wr(2'd2, 12'h000);
    send_rx(8'h99, 1'b0, 1'b0, 1'b1);
    repeat (64) @(negedge clk);
    reg_rd(2'd1, 1'b0, v); check("R13 nothing queued", int'(v[2]), 0);
    check("R13 no flags", int'(v[6:4]), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule